// File: doc/BRIEF.md
# Two-Wire Configuration Write Slave

This block is a write-only slave on a two-wire serial bus that loads a small bank of clock-control registers. It samples the serial clock and data lines with a fast system clock. Both lines are synchronised and glitch-filtered before any edge is taken from them. The slave recognises start and stop conditions and checks the first byte against a fixed 7-bit device address followed by a write bit. On a match it acknowledges the byte. Every data byte that follows is acknowledged and stored in sequence, beginning at register byte 0 each time a transaction starts. No sub-address byte is used.

The register contents leave the block as decoded control fields. These are a three-bit CPU frequency code, the 48/24 MHz select for the two USB/IO clocks, a two-bit output mode, and one enable bit for each clock output. From reset every output is enabled, the USB/IO clocks select 48 MHz, and the output mode is normal. Reads, clock stretching and arbitration are not supported. The acknowledge is driven through an active-high pull-down enable for an open-drain data pad.

Top module: `twi_cfg_slave`

## Requirements
- R1: After reset, cpu_freq_sel=000, clk48_sel=11, out_mode=00, and every enable output is 1. sda_oe is 0.
- R2: A first byte of 1101001 followed by write bit 0 (byte value 0xD2) is acknowledged. The slave holds sda_oe high through the ninth clock pulse.
- R3: A first byte with any other address, or with the read bit 1, gets no acknowledge. All data bytes after it, up to the next stop or start, get no acknowledge and change no register.
- R4: Each data byte is shifted in MSB first and acknowledged. The n-th data byte after the address (counting from 0) is written to register byte n.
- R5: Register byte 0 holds cpu_freq_sel in bits 6:4 and clk48_sel in bits 3:2, where 1 selects 48 MHz and 0 selects 24 MHz. It holds out_mode in bits 1:0, where 00 is normal, 01 is test, 11 is three-state and 10 is not applicable.
- R6: Register byte 1 drives en_clk48 from bits 7:6 and en_cpu from bits 3:0. Byte 2 drives en_pci_free from bit 6 and en_pci from bits 5:0. Byte 3 drives en_sdram from bits 7:0. Byte 5 drives en_ioapic from bit 4 and en_ref from bits 1:0.
- R7: The bits not listed in R5/R6, all of bytes 4 and 6, and any data byte past byte 6 are acknowledged but have no effect on any output.
- R8: A stop condition in the middle of a data byte discards that partial byte. Bytes completed earlier in the same transaction keep their new values.
- R9: A pulse on either line that lasts fewer than FILT_LEN (default 3) system clock samples is ignored. It produces no clock edge and no start or stop.
- R10: If SDATA changes in the same system cycle as SCLK rises, the change counts as a data bit carrying the new SDATA value. It is not a start or stop.
- R11: A repeated start, with no stop before it, begins a new address phase. The data bytes that follow it load again from register byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Pull data line low (acknowledge) |
| cpu_freq_sel | output | 3 | CPU frequency code, byte 0 bits 6:4 |
| clk48_sel | output | 2 | USB/IO clock frequency select, 1 = 48 MHz |
| out_mode | output | 2 | Output mode: 00 normal, 01 test, 11 three-state |
| en_clk48 | output | 2 | Enables of the two USB/IO clocks |
| en_cpu | output | 4 | CPU clock enables |
| en_pci | output | 6 | Stoppable PCI clock enables |
| en_pci_free | output | 1 | Free-running PCI clock enable |
| en_sdram | output | 8 | SDRAM clock enables |
| en_ioapic | output | 1 | IOAPIC clock enable |
| en_ref | output | 2 | Reference clock enables |

## Verification
Both line filters have the same latency. A data transition made together with a clock rise therefore reaches the protocol logic in the same cycle as the clock edge, and the start/stop detector and the bit sampler see the two changes at once. The bench provokes this by driving SDATA and SCLK in the same system cycle for most bits of some bytes, in both directions of SDATA change. The test passes when the byte comes through intact, is acknowledged, and the transaction is not cut short. Glitch pulses just under the filter length, placed on either line in both bus phases, are checked the same way.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK,
        ST_SKIP
    } bus_state_e;

    // bits of each register byte that are stored; others read as zero
    function automatic logic [7:0] cfg_keep_mask(input int unsigned idx);
        logic [7:0] m;
        case (idx)
            0:       m = 8'h7F;
            1:       m = 8'hCF;
            2:       m = 8'h7F;
            3:       m = 8'hFF;
            5:       m = 8'h13;
            default: m = 8'h00;
        endcase
        return m;
    endfunction

    // reset image: all enables on, USB/IO clocks at 48 MHz, normal mode
    function automatic logic [7:0] cfg_reset_val(input int unsigned idx);
        logic [7:0] v;
        case (idx)
            0:       v = 8'h0C;
            1:       v = 8'hCF;
            2:       v = 8'h7F;
            3:       v = 8'hFF;
            5:       v = 8'h13;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
    localparam int unsigned MSB   = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   level;
        logic                   rise;
        logic                   fall;
    } filt_s;

    filt_s filt_d, filt_q;

    always_comb begin
        filt_d      = filt_q;
        filt_d.rise = 1'b0;
        filt_d.fall = 1'b0;
        filt_d.sync = {filt_q.sync[SYNC_STAGES-2:0], line_i};
        if (filt_q.sync[MSB] == filt_q.level) begin
            filt_d.cnt = '0;
        end else if (filt_q.cnt == CNT_W'(FILT_LEN - 1)) begin
            filt_d.cnt   = '0;
            filt_d.level = filt_q.sync[MSB];
            filt_d.rise  = filt_q.sync[MSB];
            filt_d.fall  = ~filt_q.sync[MSB];
        end else begin
            filt_d.cnt = filt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q.sync  <= '1;
            filt_q.cnt   <= '0;
            filt_q.level <= 1'b1;
            filt_q.rise  <= 1'b0;
            filt_q.fall  <= 1'b0;
        end else begin
            filt_q <= filt_d;
        end
    end

    assign level_o = filt_q.level;
    assign rise_o  = filt_q.rise;
    assign fall_o  = filt_q.fall;

    // R9: a level change needs the synchronised line to agree for the last samples
    p_filter_min_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q.level) |->
            ($past(filt_q.sync[MSB]) == filt_q.level) &&
            ($past(filt_q.sync[MSB], 2) == filt_q.level));

endmodule

// File: rtl/twi_cfg_regbank.sv
module twi_cfg_regbank
    import twi_cfg_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 7,
    parameter int unsigned IDX_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  logic [7:0]                wr_data_i,
    output logic [NUM_BYTES-1:0][7:0] cfg_o
);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        localparam logic [7:0] KEEP = cfg_keep_mask(g);
        localparam logic [7:0] RST  = cfg_reset_val(g);
        if (KEEP == 8'h00) begin : g_none
            assign cfg_o[g] = 8'h00;
        end else begin : g_reg
            logic [7:0] byte_d, byte_q;
            always_comb begin
                byte_d = byte_q;
                if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                    byte_d = wr_data_i & KEEP;
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) byte_q <= RST;
                else        byte_q <= byte_d;
            end
            assign cfg_o[g] = byte_q;
        end
    end

    logic slot_dead;
    always_comb begin
        slot_dead = (int'(wr_idx_i) >= NUM_BYTES) ||
                    (cfg_keep_mask(int'(wr_idx_i)) == 8'h00);
    end

    // R7: writes to unused or out-of-range slots leave every register alone
    p_dead_slot_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && slot_dead) |=> $stable(cfg_o));

endmodule

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave
    import twi_cfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'b1101001,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3,
    parameter int unsigned NUM_BYTES   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [2:0] cpu_freq_sel,
    output logic [1:0] clk48_sel,
    output logic [1:0] out_mode,
    output logic [1:0] en_clk48,
    output logic [3:0] en_cpu,
    output logic [5:0] en_pci,
    output logic       en_pci_free,
    output logic [7:0] en_sdram,
    output logic       en_ioapic,
    output logic [1:0] en_ref
);
    localparam int unsigned IDX_W    = $clog2(NUM_BYTES + 1);
    localparam logic [7:0]  ADDR_WR  = {DEV_ADDR, 1'b0};
    localparam int unsigned N_LINES  = 2;
    localparam int unsigned L_SDA    = 0;
    localparam int unsigned L_SCL    = 1;

    // ---------------- line conditioning ----------------
    logic [N_LINES-1:0] line_raw, line_lvl, line_rise, line_fall;
    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        twi_glitch_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) filt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line_raw[g]),
            .level_o (line_lvl[g]),
            .rise_o  (line_rise[g]),
            .fall_o  (line_fall[g])
        );
    end

    logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
    assign scl_lvl  = line_lvl[L_SCL];
    assign scl_rise = line_rise[L_SCL];
    assign scl_fall = line_fall[L_SCL];
    assign sda_lvl  = line_lvl[L_SDA];
    assign sda_rise = line_rise[L_SDA];
    assign sda_fall = line_fall[L_SDA];

    // a data edge counts as start/stop only while SCL was already high
    logic start_det, stop_det;
    assign start_det = sda_fall && scl_lvl && !scl_rise;
    assign stop_det  = sda_rise && scl_lvl && !scl_rise;

    // ---------------- protocol engine ----------------
    typedef struct packed {
        bus_state_e       st;
        logic [7:0]       shreg;
        logic [3:0]       bits;
        logic [IDX_W-1:0] idx;
        logic             ack;
        logic             wr;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.wr = 1'b0;
        if (fsm_q.wr && (fsm_q.idx != IDX_W'(NUM_BYTES))) begin
            fsm_d.idx = fsm_q.idx + 1'b1;
        end
        if (stop_det) begin
            fsm_d.st   = ST_IDLE;
            fsm_d.ack  = 1'b0;
            fsm_d.bits = '0;
        end else if (start_det) begin
            fsm_d.st    = ST_ADDR;
            fsm_d.ack   = 1'b0;
            fsm_d.bits  = '0;
            fsm_d.idx   = '0;
            fsm_d.shreg = '0;
        end else begin
            unique case (fsm_q.st)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && (fsm_q.bits < 4'd8)) begin
                        fsm_d.shreg = {fsm_q.shreg[6:0], sda_lvl};
                        fsm_d.bits  = fsm_q.bits + 4'd1;
                        if ((fsm_q.st == ST_DATA) && (fsm_q.bits == 4'd7)) begin
                            fsm_d.wr = 1'b1;
                        end
                    end else if (scl_fall && (fsm_q.bits == 4'd8)) begin
                        fsm_d.bits = '0;
                        if ((fsm_q.st == ST_DATA) || (fsm_q.shreg == ADDR_WR)) begin
                            fsm_d.ack = 1'b1;
                            fsm_d.st  = ST_ACK;
                        end else begin
                            fsm_d.st  = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        fsm_d.ack = 1'b0;
                        fsm_d.st  = ST_DATA;
                    end
                end
                ST_IDLE, ST_SKIP: begin
                end
                default: begin
                    fsm_d.st  = ST_IDLE;
                    fsm_d.ack = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st    <= ST_IDLE;
            fsm_q.shreg <= '0;
            fsm_q.bits  <= '0;
            fsm_q.idx   <= '0;
            fsm_q.ack   <= 1'b0;
            fsm_q.wr    <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe = fsm_q.ack;

    // ---------------- register bank ----------------
    logic [NUM_BYTES-1:0][7:0] cfg;

    twi_cfg_regbank #(
        .NUM_BYTES (NUM_BYTES),
        .IDX_W     (IDX_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (fsm_q.wr),
        .wr_idx_i  (fsm_q.idx),
        .wr_data_i (fsm_q.shreg),
        .cfg_o     (cfg)
    );

    assign cpu_freq_sel = cfg[0][6:4];
    assign clk48_sel    = cfg[0][3:2];
    assign out_mode     = cfg[0][1:0];
    assign en_clk48     = cfg[1][7:6];
    assign en_cpu       = cfg[1][3:0];
    assign en_pci_free  = cfg[2][6];
    assign en_pci       = cfg[2][5:0];
    assign en_sdram     = cfg[3];
    assign en_ioapic    = cfg[5][4];
    assign en_ref       = cfg[5][1:0];

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg[0][7], cfg[1][5:4], cfg[2][7], cfg[4],
                               cfg[5][7:5], cfg[5][3:2], cfg[NUM_BYTES-1:6]};

    // ---------------- assertions ----------------
    // R3: no acknowledge while the transaction is being ignored
    p_quiet_when_skipping_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_SKIP) |-> !sda_oe);

    // R4: a register write only follows a filtered clock rise
    p_write_on_clock_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.wr |-> $past(scl_rise));

    // R4: the byte slot only advances within a transaction
    p_slot_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !start_det |=> (fsm_q.idx >= $past(fsm_q.idx)));

    // R8: the bus is released once a stop is seen
    p_release_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R11: a (repeated) start rewinds the byte slot
    p_rewind_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (fsm_q.idx == '0) && (fsm_q.st == ST_ADDR));

endmodule

// File: tb/twi_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module twi_cfg_slave_tb_top;
    localparam int Q = 10;          // system cycles per quarter bus bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line;

    logic       sda_oe;
    logic [2:0] cpu_freq_sel;
    logic [1:0] clk48_sel, out_mode, en_clk48, en_ref;
    logic [3:0] en_cpu;
    logic [5:0] en_pci;
    logic       en_pci_free, en_ioapic;
    logic [7:0] en_sdram;

    always #2.5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    twi_cfg_slave dut_i (
        .clk (clk), .rst_n (rst_n), .scl_i (scl_drv), .sda_i (sda_line),
        .sda_oe (sda_oe), .cpu_freq_sel (cpu_freq_sel), .clk48_sel (clk48_sel),
        .out_mode (out_mode), .en_clk48 (en_clk48), .en_cpu (en_cpu),
        .en_pci (en_pci), .en_pci_free (en_pci_free), .en_sdram (en_sdram),
        .en_ioapic (en_ioapic), .en_ref (en_ref)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q [0:6];
    logic [7:0] txbuf [0:11];

    function automatic logic [7:0] keep_of(input int idx);
        case (idx)
            0: return 8'h7F;
            1: return 8'hCF;
            2: return 8'h7F;
            3: return 8'hFF;
            5: return 8'h13;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input int idx, input logic [7:0] v);
        if (idx < 7) exp_q[idx] = v & keep_of(idx);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_val(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check_val({tag, " byte0"}, {1'b0, cpu_freq_sel, clk48_sel, out_mode}, exp_q[0]);
        check_val({tag, " byte1"}, {en_clk48, 2'b00, en_cpu}, exp_q[1]);
        check_val({tag, " byte2"}, {1'b0, en_pci_free, en_pci}, exp_q[2]);
        check_val({tag, " byte3"}, en_sdram, exp_q[3]);
        check_val({tag, " byte5"}, {3'b000, en_ioapic, 2'b00, en_ref}, exp_q[5]);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(2 * Q);
    endtask

    task automatic put_bit(input logic b, input bit together);
        if (together) begin
            sda_drv = b; scl_drv = 1'b1; tick(2 * Q);
        end else begin
            sda_drv = b; tick(Q);
            scl_drv = 1'b1; tick(2 * Q);
        end
        scl_drv = 1'b0; tick(Q);
    endtask

    // bit with a short SCL pulse while low and a short SDA pulse while high
    task automatic put_bit_glitchy(input logic b);
        sda_drv = b; tick(Q / 2);
        scl_drv = 1'b1; tick(2); scl_drv = 1'b0;
        tick(Q / 2);
        scl_drv = 1'b1; tick(Q / 2);
        sda_drv = ~b; tick(2); sda_drv = b;
        tick(2 * Q - Q / 2 - 2);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic take_ack(output logic acked);
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        acked = sda_oe;
        tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit together, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i], together && (i != 7));
        take_ack(acked);
    endtask

    task automatic write_txn(input logic [7:0] addr_byte, input int n,
                             input bit together, input string tag);
        logic a;
        logic match;
        match = (addr_byte == 8'hD2);
        bus_start();
        put_byte(addr_byte, 1'b0, a);
        check_val({tag, " address ack"}, {7'd0, a}, {7'd0, match});
        for (int k = 0; k < n; k++) begin
            put_byte(txbuf[k], together, a);
            check_val({tag, " data ack"}, {7'd0, a}, {7'd0, match});
            if (match) model_write(k, txbuf[k]);
        end
        bus_stop();
        tick(4);
        check_regs(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic a;
        void'($urandom(32'd2024));
        for (int i = 0; i < 7; i++) exp_q[i] = 8'h00;
        exp_q[0] = 8'h0C; exp_q[1] = 8'hCF; exp_q[2] = 8'h7F;
        exp_q[3] = 8'hFF; exp_q[5] = 8'h13;
        tick(5);
        rst_n = 1'b1;
        tick(10);

        // R1: defaults
        check_regs("R1 reset");
        check_val("R1 sda_oe idle", {7'd0, sda_oe}, 8'h00);

        // R2 R4 R5 R6: full image, pattern A
        txbuf[0] = 8'h5B; txbuf[1] = 8'h4A; txbuf[2] = 8'h25;
        txbuf[3] = 8'hA6; txbuf[4] = 8'h00; txbuf[5] = 8'h12; txbuf[6] = 8'h00;
        write_txn(8'hD2, 7, 1'b0, "R2 R4 R5 R6 pattern A");

        // R5 R6: pattern B, partial length
        txbuf[0] = 8'h21; txbuf[1] = 8'h85; txbuf[2] = 8'h5A; txbuf[3] = 8'h3C;
        write_txn(8'hD2, 4, 1'b0, "R5 R6 pattern B");

        // R7: reserved bits, bytes 4 and 6, bytes past 6
        for (int k = 0; k < 9; k++) txbuf[k] = 8'hFF;
        write_txn(8'hD2, 9, 1'b0, "R7 reserved and overflow");

        // R3: wrong address, then read bit
        txbuf[0] = 8'h00; txbuf[1] = 8'h00; txbuf[2] = 8'h00;
        write_txn(8'hA4, 3, 1'b0, "R3 wrong address");
        write_txn(8'hD3, 3, 1'b0, "R3 read bit");

        // R8: stop inside the second data byte
        bus_start();
        put_byte(8'hD2, 1'b0, a);
        put_byte(8'h01, 1'b0, a);
        check_val("R8 byte0 ack", {7'd0, a}, 8'h01);
        model_write(0, 8'h01);
        put_bit(1'b0, 1'b0); put_bit(1'b0, 1'b0); put_bit(1'b0, 1'b0);
        bus_stop();
        tick(4);
        check_regs("R8 partial byte dropped");

        // R9: glitches on both lines in both phases
        bus_start();
        put_byte(8'hD2, 1'b0, a);
        for (int i = 7; i >= 0; i--) put_bit_glitchy(8'h96 >> i);
        take_ack(a);
        check_val("R9 ack after glitches", {7'd0, a}, 8'h01);
        model_write(0, 8'h96);
        bus_stop();
        tick(4);
        check_regs("R9 glitch rejection");

        // R10: SDA changes together with SCL rise
        txbuf[0] = 8'h6A; txbuf[1] = 8'h35; txbuf[2] = 8'h5A; txbuf[3] = 8'hA5;
        write_txn(8'hD2, 4, 1'b1, "R10 simultaneous edges");

        // R11: repeated start restarts at byte 0
        bus_start();
        put_byte(8'hD2, 1'b0, a);
        put_byte(8'h30, 1'b0, a); model_write(0, 8'h30);
        put_byte(8'h0F, 1'b0, a); model_write(1, 8'h0F);
        bus_start();
        put_byte(8'hD2, 1'b0, a);
        check_val("R11 re-address ack", {7'd0, a}, 8'h01);
        put_byte(8'h4D, 1'b0, a); model_write(0, 8'h4D);
        bus_stop();
        tick(4);
        check_regs("R11 repeated start");

        // random mix (R3 R4 R7 R10)
        for (int t = 0; t < 20; t++) begin
            logic [7:0] adr;
            int n;
            bit tog;
            adr = 8'hD2;
            if (($urandom % 5) == 0) begin
                adr = 8'($urandom);
                if (adr == 8'hD2) adr = 8'hD0;
            end
            n = 1 + int'($urandom % 9);
            tog = bit'($urandom % 2);
            for (int k = 0; k < n; k++) txbuf[k] = 8'($urandom);
            write_txn(adr, n, tog, "R3 R4 R7 R10 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule